// File: doc/BRIEF.md
# Wake-up Carrier-Check Power Sequencer

This block is the power-sequencing controller of a low-power radio receiver. Once armed, it keeps the synthesizer and receiver powered off until a falling edge arrives on a chosen wake pin. It can then run a synthesizer calibration, depending on how many wakes have occurred. After that it powers the receiver, lets it settle for a programmed time, and watches a carrier-sense input for a programmed window. If carrier appears, the block stays in receive and raises a one-cycle interrupt to the host. If no carrier appears, it returns to power-down and waits for the next wake.

Automatic sequencing runs only when the 2-bit power mode equals binary 11. With any other mode value, the block is idle and the host's manual power controls drive the power enables directly. Calibration runs through a start/done handshake with an outer calibration engine. A fixed timeout guards that handshake and aborts the sequence with an error flag if it expires. The analog blocks and the signal-strength measurement are outside the block; carrier sense reaches it as a single input.

Top module: `wake_seq_ctrl`

## Requirements
- R1: While and after synchronous reset, seq_state reads 0 (idle), and synth_pwr, rx_pwr, cal_start, wake_irq and cal_err are all low.
- R2: When pd_mode is not 2'b11, seq_state is 0, synth_pwr follows man_synth_pwr and rx_pwr follows man_rx_pwr, and wake pins have no effect. Leaving mode 11 from any state returns seq_state to 0.
- R3: With pd_mode = 2'b11, a one-cycle seq_pd_set pulse moves the block to power-down (seq_state 1) from any state. In power-down both power enables are low. The same pulse clears cal_err.
- R4: Each wake pin passes through a two-flop synchronizer. With wake_sel = 1, a high-to-low transition on pin_csn starts a sequence. With wake_sel = 0, a high-to-low transition on pin_dio starts one only when sep_dio = 1. The pin that is not selected is ignored.
- R5: The settle state (seq_state 3) lasts exactly (rx_wait+1)*32 cycles, with synth_pwr and rx_pwr both high.
- R6: The sense state (seq_state 4) lasts exactly (cs_wait+1)*16 cycles when carrier_sense stays low. The block then returns to power-down (seq_state 1).
- R7: An 8-bit wrapping wake counter starts at 0 and counts each accepted wake. Calibration is due when the counter value before that wake meets the cal_mode condition: 00 = always; 01 = low 4 bits zero; 10 = all 8 bits zero; 11 = never. If calibration is not due, the wake goes straight to settle.
- R8: When calibration is due, the block enters the calibrate state (seq_state 2). cal_start is high for exactly the first cycle of that state. In this state synth_pwr is high and rx_pwr is low. A high cal_done moves the block to settle on the next cycle.
- R9: If cal_done does not arrive within 4096 cycles of entering calibrate, the block returns to power-down after exactly 4096 cycles in that state and sets cal_err.
- R10: If carrier_sense is high on any cycle of the sense state, the next cycle is the receive state (seq_state 5) with wake_irq high for one cycle. The block stays in receive with both enables high until seq_pd_set. Wake edges in any state other than power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_mode | input | 2 | Power mode; 2'b11 selects automatic sequencing |
| seq_pd_set | input | 1 | One-cycle pulse that arms power-down |
| wake_sel | input | 1 | 1 = wake on pin_csn, 0 = wake on pin_dio |
| sep_dio | input | 1 | Enables pin_dio as a wake source |
| rx_wait | input | 3 | Settle time, in units of 32 cycles, minus one |
| cs_wait | input | 4 | Carrier window, in units of 16 cycles, minus one |
| cal_mode | input | 2 | Calibration frequency selection |
| man_synth_pwr | input | 1 | Manual synthesizer enable used outside mode 11 |
| man_rx_pwr | input | 1 | Manual receiver enable used outside mode 11 |
| pin_csn | input | 1 | Asynchronous chip-select wake pin |
| pin_dio | input | 1 | Asynchronous data I/O wake pin |
| carrier_sense | input | 1 | Carrier detected level |
| cal_done | input | 1 | Calibration finished |
| synth_pwr | output | 1 | Synthesizer power enable |
| rx_pwr | output | 1 | Receiver power enable |
| cal_start | output | 1 | One-cycle calibration start strobe |
| wake_irq | output | 1 | One-cycle carrier-found interrupt |
| cal_err | output | 1 | Calibration timeout flag |
| seq_state | output | 3 | Current state code |

## Verification
The assertions assume that reset is held for several cycles, so the pin synchronizers start from the idle-high level. They also assume that cal_done arrives only while a calibration is pending and that configuration fields stay constant for the whole of a sequence. The bench drives the wake pins high at reset and changes configuration only while the block is idle or in power-down. Its calibration responder answers only after it sees cal_start, and it can be switched off to force the timeout.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    localparam int WAKE_CNT_W = 8;
    localparam logic [1:0] AUTO_MODE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PDOWN  = 3'd1,
        ST_CAL    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_SENSE  = 3'd4,
        ST_RX     = 3'd5
    } seq_st_t;

    typedef enum logic [1:0] {
        CAL_EVERY = 2'b00,
        CAL_16TH  = 2'b01,
        CAL_256TH = 2'b10,
        CAL_NEVER = 2'b11
    } cal_mode_t;

    typedef struct packed {
        logic [1:0] pd_mode;
        logic       wake_sel;
        logic       sep_dio;
        logic [2:0] rx_wait;
        logic [3:0] cs_wait;
        cal_mode_t  cal_mode;
    } seq_cfg_t;

    function automatic logic cal_is_due(cal_mode_t m, logic [WAKE_CNT_W-1:0] c);
        case (m)
            CAL_EVERY: return 1'b1;
            CAL_16TH:  return (c[3:0] == 4'd0);
            CAL_256TH: return (c == '0);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wseq_wake_det.sv
module wseq_wake_det #(
    parameter int N_PINS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pins,
    output logic [N_PINS-1:0] fall
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b1;
                s2   <= 1'b1;
                prev <= 1'b1;
            end else begin
                s1   <= pins[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign fall[i] = prev & ~s2;

        assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
            fall[i] |=> !fall[i]);
    end
endmodule

// File: rtl/wseq_cal_gate.sv
module wseq_cal_gate
    import wseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cal_mode_t mode,
    input  logic      accept,
    output logic      due
);
    logic [WAKE_CNT_W-1:0] wake_cnt;

    always_ff @(posedge clk) begin
        if (rst)         wake_cnt <= '0;
        else if (accept) wake_cnt <= wake_cnt + 1'b1;
    end

    assign due = cal_is_due(mode, wake_cnt);

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(accept) |-> wake_cnt == $past(wake_cnt));
endmodule

// File: rtl/wseq_timer.sv
module wseq_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    assert_tmr_down_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt) != '0) |-> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
    import wseq_pkg::*;
#(
    parameter int SETTLE_UNIT = 32,
    parameter int WINDOW_UNIT = 16,
    parameter int CAL_TIMEOUT = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pd_mode,
    input  logic       seq_pd_set,
    input  logic       wake_sel,
    input  logic       sep_dio,
    input  logic [2:0] rx_wait,
    input  logic [3:0] cs_wait,
    input  logic [1:0] cal_mode,
    input  logic       man_synth_pwr,
    input  logic       man_rx_pwr,
    input  logic       pin_csn,
    input  logic       pin_dio,
    input  logic       carrier_sense,
    input  logic       cal_done,
    output logic       synth_pwr,
    output logic       rx_pwr,
    output logic       cal_start,
    output logic       wake_irq,
    output logic       cal_err,
    output logic [2:0] seq_state
);
    localparam int SETTLE_MAX = 8 * SETTLE_UNIT;
    localparam int WINDOW_MAX = 16 * WINDOW_UNIT;
    localparam int LEN_A  = (SETTLE_MAX > WINDOW_MAX) ? SETTLE_MAX : WINDOW_MAX;
    localparam int MAXLEN = (LEN_A > CAL_TIMEOUT) ? LEN_A : CAL_TIMEOUT;
    localparam int TMR_W  = $clog2(MAXLEN);

    seq_cfg_t cfg;
    assign cfg = '{pd_mode: pd_mode, wake_sel: wake_sel, sep_dio: sep_dio,
                   rx_wait: rx_wait, cs_wait: cs_wait,
                   cal_mode: cal_mode_t'(cal_mode)};

    seq_st_t           st, nxt;
    logic              auto_on;
    logic [1:0]        falls;
    logic              wake_ev, accept, due;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val, settle_len, window_len;
    logic              abort, detect;

    assign auto_on = (cfg.pd_mode == AUTO_MODE);

    wseq_wake_det #(.N_PINS(2)) u_wake (
        .clk (clk),
        .rst (rst),
        .pins({pin_dio, pin_csn}),
        .fall(falls)
    );

    assign wake_ev = cfg.wake_sel ? falls[0] : (cfg.sep_dio & falls[1]);
    assign accept  = auto_on & ~seq_pd_set & (st == ST_PDOWN) & wake_ev;

    wseq_cal_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .mode  (cfg.cal_mode),
        .accept(accept),
        .due   (due)
    );

    assign settle_len = TMR_W'((32'(cfg.rx_wait) + 1) * SETTLE_UNIT - 1);
    assign window_len = TMR_W'((32'(cfg.cs_wait) + 1) * WINDOW_UNIT - 1);

    always_comb begin
        nxt     = st;
        tmr_val = '0;
        abort   = 1'b0;
        detect  = 1'b0;
        if (!auto_on) begin
            nxt = ST_IDLE;
        end else if (seq_pd_set) begin
            nxt = ST_PDOWN;
        end else begin
            case (st)
                ST_PDOWN: if (wake_ev) begin
                    if (due) begin
                        nxt     = ST_CAL;
                        tmr_val = TMR_W'(CAL_TIMEOUT - 1);
                    end else begin
                        nxt     = ST_SETTLE;
                        tmr_val = settle_len;
                    end
                end
                ST_CAL: if (cal_done) begin
                    nxt     = ST_SETTLE;
                    tmr_val = settle_len;
                end else if (tmr_zero) begin
                    nxt   = ST_PDOWN;
                    abort = 1'b1;
                end
                ST_SETTLE: if (tmr_zero) begin
                    nxt     = ST_SENSE;
                    tmr_val = window_len;
                end
                ST_SENSE: if (carrier_sense) begin
                    nxt    = ST_RX;
                    detect = 1'b1;
                end else if (tmr_zero) begin
                    nxt = ST_PDOWN;
                end
                default: nxt = st;
            endcase
        end
    end

    assign tmr_load = (nxt != st);

    wseq_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cal_start <= 1'b0;
            wake_irq  <= 1'b0;
            cal_err   <= 1'b0;
        end else begin
            st        <= nxt;
            cal_start <= (st == ST_PDOWN) && (nxt == ST_CAL);
            wake_irq  <= detect;
            if (auto_on && seq_pd_set) cal_err <= 1'b0;
            else if (abort)            cal_err <= 1'b1;
        end
    end

    always_comb begin
        if (!auto_on) begin
            synth_pwr = man_synth_pwr;
            rx_pwr    = man_rx_pwr;
        end else begin
            synth_pwr = (st == ST_CAL) || (st == ST_SETTLE) ||
                        (st == ST_SENSE) || (st == ST_RX);
            rx_pwr    = (st == ST_SETTLE) || (st == ST_SENSE) || (st == ST_RX);
        end
    end

    assign seq_state = st;

    assert_cal_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> !cal_start);

    assert_irq_entry_R10: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> (st == ST_RX && $past(st) == ST_SENSE));

    assert_pdown_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PDOWN && auto_on) |-> (!rx_pwr && !synth_pwr));

    assert_settle_exit_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_SETTLE && st == ST_SENSE) |-> $past(tmr_zero));

    assert_err_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_err) |-> ($past(st) == ST_CAL && st == ST_PDOWN));
endmodule

// File: tb/sim_wake_seq_ctrl.sv
`timescale 1ns/1ps
module sim_wake_seq_ctrl;
    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] pd_mode = 2'b00;
    logic seq_pd_set = 0, wake_sel = 1, sep_dio = 0;
    logic [2:0] rx_wait = 0;
    logic [3:0] cs_wait = 0;
    logic [1:0] cal_mode = 2'b11;
    logic man_synth_pwr = 0, man_rx_pwr = 0;
    logic pin_csn = 1, pin_dio = 1, carrier_sense = 0, cal_done = 0;
    logic synth_pwr, rx_pwr, cal_start, wake_irq, cal_err;
    logic [2:0] seq_state;

    int n_checks = 0, n_fail = 0, n_cal = 0, wakes = 0;
    bit resp_en = 1'b1, finished = 1'b0;

    always #4 clk = ~clk;

    wake_seq_ctrl u0 (.*);

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(int s, int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (seq_state == 3'(s)) return;
            @(negedge clk);
        end
    endtask

    task automatic fall_pin(bit on_dio);
        if (on_dio) pin_dio = 0; else pin_csn = 0;
        cyc(4);
        pin_dio = 1; pin_csn = 1;
        cyc(4);
    endtask

    task automatic arm;
        seq_pd_set = 1; cyc(1); seq_pd_set = 0;
    endtask

    initial forever begin
        @(negedge clk);
        if (cal_start) n_cal++;
    end

    initial forever begin
        @(negedge clk);
        if (resp_en && cal_start) begin
            cyc(3); cal_done = 1; cyc(1); cal_done = 0;
        end
    end

    task automatic t_reset;
        cyc(3);
        chk("R1 state", seq_state, 0);
        chk("R1 outs", {synth_pwr, rx_pwr, cal_start, wake_irq, cal_err}, 0);
        rst = 0; cyc(2);
        chk("R1 after", {seq_state, synth_pwr, rx_pwr, cal_err}, 0);
    endtask

    task automatic t_manual;
        man_rx_pwr = 1; man_synth_pwr = 0; cyc(1);
        chk("R2 rx follow", {synth_pwr, rx_pwr}, 1);
        man_rx_pwr = 0; man_synth_pwr = 1; cyc(1);
        chk("R2 synth follow", {synth_pwr, rx_pwr}, 2);
        fall_pin(0); cyc(5);
        chk("R2 wake ignored", seq_state, 0);
        man_synth_pwr = 0;
    endtask

    task automatic t_never_settle;
        int ns = 0, nw = 0;
        pd_mode = 2'b11; cal_mode = 2'b11; rx_wait = 2; cs_wait = 1; cyc(2);
        chk("R3 idle before arm", seq_state, 0);
        arm(); cyc(1);
        chk("R3 pdown", seq_state, 1);
        chk("R3 pwr off", {synth_pwr, rx_pwr}, 0);
        wake_sel = 1; pin_csn = 0;
        wait_state(3, 20);
        pin_csn = 1;
        chk("R7 never skips cal", n_cal, 0);
        chk("R5 pwr in settle", {synth_pwr, rx_pwr}, 3);
        while (seq_state == 3 && ns < 1000) begin ns++; cyc(1); end
        chk("R5 settle length", ns, 96);
        while (seq_state == 4 && nw < 1000) begin nw++; cyc(1); end
        chk("R6 window length", nw, 32);
        chk("R6 back to pdown", seq_state, 1);
        wakes++;
    endtask

    task automatic t_dio;
        rx_wait = 0; cs_wait = 0;
        wake_sel = 0; sep_dio = 0;
        fall_pin(1); cyc(5);
        chk("R4 dio gated off", seq_state, 1);
        fall_pin(0); cyc(5);
        chk("R4 csn unselected", seq_state, 1);
        sep_dio = 1;
        fall_pin(1);
        chk("R4 dio wakes", seq_state, 3);
        wait_state(1, 200);
        wakes++;
    endtask

    task automatic t_carrier;
        wake_sel = 1;
        fall_pin(0);
        wait_state(4, 200);
        cyc(3);
        carrier_sense = 1; cyc(1); carrier_sense = 0;
        chk("R10 rx state", seq_state, 5);
        chk("R10 irq", wake_irq, 1);
        cyc(1);
        chk("R10 irq one cycle", wake_irq, 0);
        fall_pin(0); cyc(60);
        chk("R10 stays rx", seq_state, 5);
        chk("R10 pwr", {synth_pwr, rx_pwr}, 3);
        arm(); cyc(1);
        chk("R3 arm from rx", seq_state, 1);
        wakes++;
    endtask

    task automatic t_cal_every;
        int c0;
        cal_mode = 2'b00; c0 = n_cal;
        pin_csn = 0;
        wait_state(2, 20);
        chk("R8 cal state", seq_state, 2);
        chk("R8 strobe", cal_start, 1);
        chk("R8 pwr", {synth_pwr, rx_pwr}, 2);
        cyc(1);
        chk("R8 strobe one cycle", cal_start, 0);
        pin_csn = 1;
        wait_state(3, 20);
        chk("R8 settle after done", seq_state, 3);
        chk("R7 every wake", n_cal - c0, 1);
        wait_state(1, 200);
        wakes++;
    endtask

    task automatic t_timeout;
        int nc = 0;
        resp_en = 0;
        pin_csn = 0;
        wait_state(2, 20);
        pin_csn = 1;
        while (seq_state == 2 && nc < 5000) begin nc++; cyc(1); end
        chk("R9 cal cycles", nc, 4096);
        chk("R9 pdown", seq_state, 1);
        chk("R9 err", cal_err, 1);
        arm(); cyc(1);
        chk("R3 err cleared", cal_err, 0);
        resp_en = 1;
        wakes++;
    endtask

    task automatic t_gate(int mode, int n);
        int exp = 0, c0;
        cal_mode = 2'(mode); c0 = n_cal;
        for (int i = 0; i < n; i++) begin
            int c;
            c = wakes % 256;
            if (mode == 1 && (c % 16) == 0) exp++;
            if (mode == 2 && c == 0) exp++;
            fall_pin(0);
            wait_state(1, 300);
            wakes++;
        end
        chk(mode == 1 ? "R7 every 16th" : "R7 every 256th", n_cal - c0, exp);
    endtask

    task automatic t_leave;
        fall_pin(0);
        wait_state(4, 200);
        pd_mode = 2'b01; cyc(1);
        chk("R2 leave to idle", seq_state, 0);
        chk("R2 manual pwr", {synth_pwr, rx_pwr}, 0);
    endtask

    initial begin
        t_reset();
        t_manual();
        t_never_settle();
        t_dio();
        t_carrier();
        t_cal_every();
        t_timeout();
        t_gate(1, 27);
        t_gate(2, 256);
        t_leave();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule